// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block sits behind the write side of an asynchronous-style parallel NOR flash port after the host strobes have been brought into the clock domain. Each cycle with `wr_stb` high carries one host write: a word address and a 16-bit data word. The decoder follows the unlock-protected command sequences written on that port. When a sequence completes, it raises a one-cycle command request for the internal program/erase engine and the read-path multiplexer. A program request carries the target address and word. An erase request carries the sector or block index.

It keeps the current read view (array, identification, query table or security area) and drops program and erase requests aimed at the protected boot block while write protect is low. While the engine reports a program or erase in progress, it ignores writes. The one exception is the erase-suspend code during an erase. It also remembers which sector or block is suspended and refuses new erases and programs into that region until a resume.

The write port has no back-pressure: every strobe is taken in the cycle it appears. `cmd_valid` has no ready, so the consumer must take each one-cycle request when it appears. Mode, busy and protect pins are plain levels.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `cmd_valid` is 0, `cmd_code` is 0, `read_mode` is 0 (array), `erase_suspended` is 0, and any partly received sequence is discarded.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h, followed by any address/word, give exactly one cycle of `cmd_valid` with `cmd_code`=1 in the cycle after the fourth write, carrying that write's address on `cmd_addr` and word on `cmd_data`.
- R3: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh and then a final write give one of three requests. A final 10h@555h gives chip erase (`cmd_code`=4). A final 50h at any address gives sector erase (code 2), with `cmd_index` = address bits 20:11. A final 30h at any address gives block erase (code 3), with `cmd_index` = address bits 20:15, zero-extended.
- R4: Command cycles compare only address bits 10:0 and data bits 7:0. Address bits 20:11 and data bits 15:8 have no effect on them.
- R5: After the three-write prefix, a final write to 555h selects the read view. 90h gives ID view (code 7, `read_mode`=1). 98h gives query view (code 8, mode 2). 88h gives security view (code 9, mode 3). F0h returns to array view (code 10, mode 0).
- R6: A single write of 98h to address 55h enters query view (code 8, mode 2). A single write of F0h to any address exits to array view (code 10, mode 0).
- R7: A write that does not match the next expected cycle of a started sequence returns the decoder to idle with `read_mode`=0 and emits nothing. A later cycle of the same sequence then does nothing.
- R8: While `prog_busy` or `erase_busy` is high, writes are ignored, mode exit included: no request, no mode change, no sequence progress.
- R9: A write of B0h (any address) while `erase_busy`=1 and `prog_busy`=0 emits suspend (code 5) and sets `erase_suspended`. While suspended and not busy, a single write of 30h (any address) emits resume (code 6) and clears it. A single 30h when not suspended does nothing.
- R10: With `wp_n`=0 at the final write, program, sector erase and block erase whose address bits 20:15 are all zero (boot block, default placement) are dropped, and chip erase is always dropped. The same requests outside the boot block still pass.
- R11: While `erase_suspended`=1, all erase requests are dropped. A program into the suspended sector (or block) is dropped, and a program elsewhere passes.
- R12: Reset in the middle of a sequence discards the partial prefix, so the remaining cycles of that sequence emit nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One host write in this cycle |
| wr_addr | input | 21 | Word address of the write |
| wr_data | input | 16 | Data word of the write |
| wp_n | input | 1 | Write protect, low protects the boot block |
| prog_busy | input | 1 | Internal program in progress |
| erase_busy | input | 1 | Internal erase in progress |
| cmd_valid | output | 1 | One-cycle command request |
| cmd_code | output | 4 | Request kind (1 program … 10 exit, 0 none) |
| cmd_addr | output | 21 | Address of the final write |
| cmd_data | output | 16 | Word of the final write |
| cmd_index | output | 10 | Sector index, or block index zero-extended |
| read_mode | output | 2 | 0 array, 1 ID, 2 query, 3 security |
| erase_suspended | output | 1 | An erase is suspended |

## Verification
The decoder is driven with whole correct sequences for every command, each ending in a distinct final code, so that a swapped code-to-request mapping shows up. Further patterns use the same sequences with junk in the upper address and data bits, and sequences broken by one wrong address in the middle. Single-cycle shortcuts are sent both with and without their enabling condition (suspend with and without an erase running, resume with and without a prior suspend). Protected and unprotected targets are sent under both write-protect levels, together with programs inside and outside a suspended sector, which separates the address-based drops from the unconditional ones.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    CMD_NONE   = 4'd0,
    CMD_PROG   = 4'd1,
    CMD_SECT   = 4'd2,
    CMD_BLK    = 4'd3,
    CMD_CHIP   = 4'd4,
    CMD_SUSP   = 4'd5,
    CMD_RESUME = 4'd6,
    CMD_ID     = 4'd7,
    CMD_CFI    = 4'd8,
    CMD_SECID  = 4'd9,
    CMD_EXIT   = 4'd10
  } cmd_e;

  typedef enum logic [1:0] {
    MODE_ARRAY = 2'd0,
    MODE_ID    = 2'd1,
    MODE_CFI   = 2'd2,
    MODE_SECID = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PROG, SQ_E3, SQ_E4, SQ_E5
  } seq_e;

  localparam int CMP_W = 11;

  localparam logic [7:0] K_UNLK1  = 8'hAA;
  localparam logic [7:0] K_UNLK2  = 8'h55;
  localparam logic [7:0] K_PROG   = 8'hA0;
  localparam logic [7:0] K_ERASE  = 8'h80;
  localparam logic [7:0] K_CHIP   = 8'h10;
  localparam logic [7:0] K_SECT   = 8'h50;
  localparam logic [7:0] K_BLK    = 8'h30;
  localparam logic [7:0] K_ID     = 8'h90;
  localparam logic [7:0] K_CFI    = 8'h98;
  localparam logic [7:0] K_SECID  = 8'h88;
  localparam logic [7:0] K_EXIT   = 8'hF0;
  localparam logic [7:0] K_SUSP   = 8'hB0;
  localparam logic [7:0] K_RESUME = 8'h30;

  localparam logic [CMP_W-1:0] A_FIRST  = 11'h555;
  localparam logic [CMP_W-1:0] A_SECOND = 11'h2AA;
  localparam logic [CMP_W-1:0] A_QUERY  = 11'h055;

  typedef struct packed {
    logic       at_first;
    logic       at_second;
    logic       at_query;
    logic [7:0] code;
  } cyc_t;

endpackage

// File: rtl/flash_cmd_classify.sv
module flash_cmd_classify
  import flash_cmd_pkg::*;
(
  input  logic [CMP_W-1:0] addr_lo,
  input  logic [7:0]       data_lo,
  output cyc_t             cyc
);

  always_comb begin
    cyc.at_first  = (addr_lo == A_FIRST);
    cyc.at_second = (addr_lo == A_SECOND);
    cyc.at_query  = (addr_lo == A_QUERY);
    cyc.code      = data_lo;
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic acc,
  input  logic sus_hit,
  input  logic suspended,
  input  cyc_t cyc,
  output cmd_e kind,
  output logic abort
);

  seq_e state, nxt;

  always_comb begin
    nxt   = state;
    kind  = CMD_NONE;
    abort = 1'b0;
    if (sus_hit) begin
      kind = CMD_SUSP;
    end else if (acc) begin
      case (state)
        SQ_IDLE: begin
          if (cyc.at_first && cyc.code == K_UNLK1)       nxt  = SQ_U1;
          else if (cyc.at_query && cyc.code == K_CFI)    kind = CMD_CFI;
          else if (cyc.code == K_EXIT)                   kind = CMD_EXIT;
          else if (cyc.code == K_RESUME && suspended)    kind = CMD_RESUME;
        end
        SQ_U1: begin
          if (cyc.at_second && cyc.code == K_UNLK2) nxt = SQ_U2;
          else begin nxt = SQ_IDLE; abort = 1'b1; end
        end
        SQ_U2: begin
          nxt = SQ_IDLE;
          if (!cyc.at_first) abort = 1'b1;
          else begin
            case (cyc.code)
              K_PROG:  nxt  = SQ_PROG;
              K_ERASE: nxt  = SQ_E3;
              K_ID:    kind = CMD_ID;
              K_CFI:   kind = CMD_CFI;
              K_SECID: kind = CMD_SECID;
              K_EXIT:  kind = CMD_EXIT;
              default: abort = 1'b1;
            endcase
          end
        end
        SQ_PROG: begin
          nxt  = SQ_IDLE;
          kind = CMD_PROG;
        end
        SQ_E3: begin
          if (cyc.at_first && cyc.code == K_UNLK1) nxt = SQ_E4;
          else begin nxt = SQ_IDLE; abort = 1'b1; end
        end
        SQ_E4: begin
          if (cyc.at_second && cyc.code == K_UNLK2) nxt = SQ_E5;
          else begin nxt = SQ_IDLE; abort = 1'b1; end
        end
        SQ_E5: begin
          nxt = SQ_IDLE;
          if (cyc.at_first && cyc.code == K_CHIP) kind = CMD_CHIP;
          else if (cyc.code == K_SECT)            kind = CMD_SECT;
          else if (cyc.code == K_BLK)             kind = CMD_BLK;
          else                                    abort = 1'b1;
        end
        default: nxt = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_IDLE;
    else        state <= nxt;
  end

  // R2: the data cycle of a program always closes the sequence
  p_prog_one_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && state == SQ_PROG) |=> (state == SQ_IDLE));

  // R7: a mismatching cycle leaves the sequence idle
  p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (state == SQ_IDLE));

endmodule

// File: rtl/flash_cmd_mode.sv
module flash_cmd_mode
  import flash_cmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  cmd_e  kind,
  input  logic  abort,
  output mode_e mode
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= MODE_ARRAY;
    else if (abort) mode <= MODE_ARRAY;
    else begin
      case (kind)
        CMD_ID:    mode <= MODE_ID;
        CMD_CFI:   mode <= MODE_CFI;
        CMD_SECID: mode <= MODE_SECID;
        CMD_EXIT:  mode <= MODE_ARRAY;
        default:   mode <= mode;
      endcase
    end
  end

  // R5 / R7: exit and broken sequences both land in array view
  p_exit_to_array_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CMD_EXIT || abort) |=> (mode == MODE_ARRAY));

  // R5: ID entry selects the ID view
  p_id_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CMD_ID && !abort) |=> (mode == MODE_ID));

endmodule

// File: rtl/flash_cmd_guard.sv
module flash_cmd_guard
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 21,
  parameter int DATA_W      = 16,
  parameter int SECT_LSB    = 11,
  parameter int BLK_LSB     = 15,
  parameter bit BOOT_AT_TOP = 1'b0,
  localparam int SECT_W     = ADDR_W - SECT_LSB,
  localparam int BLK_W      = ADDR_W - BLK_LSB
)(
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              wp_n,
  output logic              cmd_valid,
  output cmd_e              cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic [SECT_W-1:0] cmd_index,
  output logic              susp_q
);

  logic [SECT_W-1:0] sect_of, idx_of, last_idx;
  logic [BLK_W-1:0]  blk_of;
  logic              last_blk, boot_hit, in_susp, drop, pass;

  assign sect_of = addr[ADDR_W-1:SECT_LSB];
  assign blk_of  = addr[ADDR_W-1:BLK_LSB];
  assign idx_of  = (kind == CMD_BLK) ? {{(SECT_W-BLK_W){1'b0}}, blk_of} : sect_of;

  generate
    if (BOOT_AT_TOP) begin : g_top_boot
      assign boot_hit = &blk_of;
    end else begin : g_bot_boot
      assign boot_hit = ~|blk_of;
    end
  endgenerate

  assign in_susp = last_blk ? (blk_of == last_idx[BLK_W-1:0]) : (sect_of == last_idx);

  always_comb begin
    case (kind)
      CMD_PROG:         drop = (!wp_n && boot_hit) || (susp_q && in_susp);
      CMD_SECT, CMD_BLK: drop = (!wp_n && boot_hit) || susp_q;
      CMD_CHIP:         drop = !wp_n || susp_q;
      default:          drop = 1'b0;
    endcase
  end

  assign pass = (kind != CMD_NONE) && !drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_code  <= CMD_NONE;
      cmd_addr  <= '0;
      cmd_data  <= '0;
      cmd_index <= '0;
      susp_q    <= 1'b0;
      last_blk  <= 1'b0;
      last_idx  <= '0;
    end else begin
      cmd_valid <= pass;
      cmd_code  <= pass ? kind : CMD_NONE;
      if (pass) begin
        cmd_addr  <= addr;
        cmd_data  <= data;
        cmd_index <= idx_of;
      end
      if (pass && (kind == CMD_SECT || kind == CMD_BLK)) begin
        last_blk <= (kind == CMD_BLK);
        last_idx <= idx_of;
      end
      if (pass && kind == CMD_SUSP)        susp_q <= 1'b1;
      else if (pass && kind == CMD_RESUME) susp_q <= 1'b0;
    end
  end

  // R10: chip erase never leaves while protect is asserted
  p_wp_chip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> !(cmd_valid && cmd_code == CMD_CHIP));

  // R9: a suspend request is always accompanied by the suspended flag
  p_susp_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CMD_SUSP) |-> susp_q);

  // R11: no erase request appears while an erase is suspended
  p_no_erase_susp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    susp_q |-> !(cmd_valid && (cmd_code == CMD_SECT || cmd_code == CMD_BLK ||
                               cmd_code == CMD_CHIP)));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 21,
  parameter int DATA_W      = 16,
  parameter int SECT_LSB    = 11,
  parameter int BLK_LSB     = 15,
  parameter bit BOOT_AT_TOP = 1'b0,
  localparam int SECT_W     = ADDR_W - SECT_LSB
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wp_n,
  input  logic              prog_busy,
  input  logic              erase_busy,
  output logic              cmd_valid,
  output logic [3:0]        cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic [SECT_W-1:0] cmd_index,
  output logic [1:0]        read_mode,
  output logic              erase_suspended
);

  cyc_t  cyc;
  cmd_e  kind, code_q;
  mode_e mode_q;
  logic  acc, sus_hit, abort, susp_q;

  assign acc     = wr_stb && !prog_busy && !erase_busy;
  assign sus_hit = wr_stb && erase_busy && !prog_busy && (wr_data[7:0] == K_SUSP);

  flash_cmd_classify u_classify (
    .addr_lo (wr_addr[CMP_W-1:0]),
    .data_lo (wr_data[7:0]),
    .cyc     (cyc)
  );

  flash_cmd_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .sus_hit   (sus_hit),
    .suspended (susp_q),
    .cyc       (cyc),
    .kind      (kind),
    .abort     (abort)
  );

  flash_cmd_mode u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .kind  (kind),
    .abort (abort),
    .mode  (mode_q)
  );

  flash_cmd_guard #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .SECT_LSB    (SECT_LSB),
    .BLK_LSB     (BLK_LSB),
    .BOOT_AT_TOP (BOOT_AT_TOP)
  ) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .kind      (kind),
    .addr      (wr_addr),
    .data      (wr_data),
    .wp_n      (wp_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (code_q),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .cmd_index (cmd_index),
    .susp_q    (susp_q)
  );

  assign cmd_code        = code_q;
  assign read_mode       = mode_q;
  assign erase_suspended = susp_q;

  // R8: nothing is requested in the cycle after a write seen during a program
  p_busy_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_busy |=> !cmd_valid);

endmodule

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [20:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        wp_n = 1'b1;
  logic        prog_busy = 1'b0;
  logic        erase_busy = 1'b0;
  logic        cmd_valid;
  logic [3:0]  cmd_code;
  logic [20:0] cmd_addr;
  logic [15:0] cmd_data;
  logic [9:0]  cmd_index;
  logic [1:0]  read_mode;
  logic        erase_suspended;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .wp_n(wp_n), .prog_busy(prog_busy), .erase_busy(erase_busy),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_index(cmd_index), .read_mode(read_mode),
    .erase_suspended(erase_suspended)
  );

  // fields: req tag(4) wp_n pb eb(3) addr(21) data(16) exp_valid(1) exp_code(4) exp_mode(2)
  localparam int NV = 53;
  localparam logic [50:0] VEC [NV] = '{
    {4'd2,  3'b100, 21'h000555, 16'h00AA, 1'b0, 4'd0,  2'd0},  // R2 program
    {4'd2,  3'b100, 21'h0002AA, 16'h0055, 1'b0, 4'd0,  2'd0},
    {4'd2,  3'b100, 21'h000555, 16'h00A0, 1'b0, 4'd0,  2'd0},
    {4'd2,  3'b100, 21'h012345, 16'h1234, 1'b1, 4'd1,  2'd0},
    {4'd5,  3'b100, 21'h000555, 16'h00AA, 1'b0, 4'd0,  2'd0},  // R5 ID entry
    {4'd5,  3'b100, 21'h0002AA, 16'h0055, 1'b0, 4'd0,  2'd0},
    {4'd5,  3'b100, 21'h000555, 16'h0090, 1'b1, 4'd7,  2'd1},
    {4'd6,  3'b100, 21'h1ABCDE, 16'h00F0, 1'b1, 4'd10, 2'd0},  // R6 single exit
    {4'd6,  3'b100, 21'h000055, 16'h0098, 1'b1, 4'd8,  2'd2},  // R6 query shortcut
    {4'd5,  3'b100, 21'h000555, 16'h00AA, 1'b0, 4'd0,  2'd2},  // R5 prefixed exit
    {4'd5,  3'b100, 21'h0002AA, 16'h0055, 1'b0, 4'd0,  2'd2},
    {4'd5,  3'b100, 21'h000555, 16'h00F0, 1'b1, 4'd10, 2'd0},
    {4'd4,  3'b100, 21'h1FF555, 16'hFFAA, 1'b0, 4'd0,  2'd0},  // R4 junk high bits
    {4'd4,  3'b100, 21'h1232AA, 16'h3355, 1'b0, 4'd0,  2'd0},
    {4'd4,  3'b100, 21'h000555, 16'h7788, 1'b1, 4'd9,  2'd3},
    {4'd7,  3'b100, 21'h000555, 16'h00AA, 1'b0, 4'd0,  2'd3},  // R7 broken prefix
    {4'd7,  3'b100, 21'h0002AB, 16'h0055, 1'b0, 4'd0,  2'd0},
    {4'd7,  3'b100, 21'h000555, 16'h00A0, 1'b0, 4'd0,  2'd0},
    {4'd3,  3'b100, 21'h000555, 16'h00AA, 1'b0, 4'd0,  2'd0},  // R3 chip erase
    {4'd3,  3'b100, 21'h0002AA, 16'h0055, 1'b0, 4'd0,  2'd0},
    {4'd3,  3'b100, 21'h000555, 16'h0080, 1'b0, 4'd0,  2'd0},
    {4'd3,  3'b100, 21'h000555, 16'h00AA, 1'b0, 4'd0,  2'd0},
    {4'd3,  3'b100, 21'h0002AA, 16'h0055, 1'b0, 4'd0,  2'd0},
    {4'd3,  3'b100, 21'h000555, 16'h0010, 1'b1, 4'd4,  2'd0},
    {4'd3,  3'b100, 21'h000555, 16'h00AA, 1'b0, 4'd0,  2'd0},  // R3 sector erase
    {4'd3,  3'b100, 21'h0002AA, 16'h0055, 1'b0, 4'd0,  2'd0},
    {4'd3,  3'b100, 21'h000555, 16'h0080, 1'b0, 4'd0,  2'd0},
    {4'd3,  3'b100, 21'h000555, 16'h00AA, 1'b0, 4'd0,  2'd0},
    {4'd3,  3'b100, 21'h0002AA, 16'h0055, 1'b0, 4'd0,  2'd0},
    {4'd3,  3'b100, 21'h0AB800, 16'h0050, 1'b1, 4'd2,  2'd0},
    {4'd10, 3'b100, 21'h000555, 16'h00AA, 1'b0, 4'd0,  2'd0},  // R10 block erase of boot block
    {4'd10, 3'b100, 21'h0002AA, 16'h0055, 1'b0, 4'd0,  2'd0},
    {4'd10, 3'b100, 21'h000555, 16'h0080, 1'b0, 4'd0,  2'd0},
    {4'd10, 3'b100, 21'h000555, 16'h00AA, 1'b0, 4'd0,  2'd0},
    {4'd10, 3'b100, 21'h0002AA, 16'h0055, 1'b0, 4'd0,  2'd0},
    {4'd10, 3'b000, 21'h003000, 16'h0030, 1'b0, 4'd0,  2'd0},
    {4'd10, 3'b100, 21'h000555, 16'h00AA, 1'b0, 4'd0,  2'd0},  // R10 chip erase protected
    {4'd10, 3'b100, 21'h0002AA, 16'h0055, 1'b0, 4'd0,  2'd0},
    {4'd10, 3'b100, 21'h000555, 16'h0080, 1'b0, 4'd0,  2'd0},
    {4'd10, 3'b100, 21'h000555, 16'h00AA, 1'b0, 4'd0,  2'd0},
    {4'd10, 3'b100, 21'h0002AA, 16'h0055, 1'b0, 4'd0,  2'd0},
    {4'd10, 3'b000, 21'h000555, 16'h0010, 1'b0, 4'd0,  2'd0},
    {4'd8,  3'b110, 21'h000555, 16'h00AA, 1'b0, 4'd0,  2'd0},  // R8 first unlock lost while busy
    {4'd8,  3'b100, 21'h0002AA, 16'h0055, 1'b0, 4'd0,  2'd0},
    {4'd8,  3'b100, 21'h000555, 16'h00A0, 1'b0, 4'd0,  2'd0},
    {4'd5,  3'b100, 21'h000555, 16'h00AA, 1'b0, 4'd0,  2'd0},
    {4'd5,  3'b100, 21'h0002AA, 16'h0055, 1'b0, 4'd0,  2'd0},
    {4'd5,  3'b100, 21'h000555, 16'h0090, 1'b1, 4'd7,  2'd1},
    {4'd8,  3'b101, 21'h000123, 16'h00F0, 1'b0, 4'd0,  2'd1},  // R8 exit ignored while erasing
    {4'd9,  3'b101, 21'h0ABCDE, 16'h00B0, 1'b1, 4'd5,  2'd1},  // R9 suspend
    {4'd9,  3'b100, 21'h155555, 16'h0030, 1'b1, 4'd6,  2'd1},  // R9 resume
    {4'd9,  3'b100, 21'h000000, 16'h0030, 1'b0, 4'd0,  2'd1},  // R9 resume without suspend
    {4'd6,  3'b100, 21'h000000, 16'h00F0, 1'b1, 4'd10, 2'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [20:0] a, input logic [15:0] d,
                          input logic wp, input logic pb, input logic eb);
    @(negedge clk);
    wr_addr = a; wr_data = d; wp_n = wp; prog_busy = pb; erase_busy = eb; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; prog_busy = 1'b0; erase_busy = 1'b0; wp_n = 1'b1;
  endtask

  task automatic prog_seq(input logic [20:0] a, input logic [15:0] d, input logic wp);
    do_write(21'h000555, 16'h00AA, wp, 1'b0, 1'b0);
    do_write(21'h0002AA, 16'h0055, wp, 1'b0, 1'b0);
    do_write(21'h000555, 16'h00A0, wp, 1'b0, 1'b0);
    do_write(a, d, wp, 1'b0, 1'b0);
  endtask

  task automatic erase_seq(input logic [20:0] a, input logic [7:0] code, input logic wp);
    do_write(21'h000555, 16'h00AA, wp, 1'b0, 1'b0);
    do_write(21'h0002AA, 16'h0055, wp, 1'b0, 1'b0);
    do_write(21'h000555, 16'h0080, wp, 1'b0, 1'b0);
    do_write(21'h000555, 16'h00AA, wp, 1'b0, 1'b0);
    do_write(21'h0002AA, 16'h0055, wp, 1'b0, 1'b0);
    do_write(a, {8'h00, code}, wp, 1'b0, 1'b0);
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 valid", cmd_valid, 0);
    chk("R1 code", cmd_code, 0);
    chk("R1 mode", read_mode, 0);
    chk("R1 suspended", erase_suspended, 0);

    for (int i = 0; i < NV; i++) begin
      logic [50:0] v;
      v = VEC[i];
      do_write(v[43:23], v[22:7], v[46], v[45], v[44]);
      chk($sformatf("R%0d row %0d valid", v[50:47], i), cmd_valid, v[6]);
      chk($sformatf("R%0d row %0d code", v[50:47], i), cmd_code, v[5:2]);
      chk($sformatf("R%0d row %0d mode", v[50:47], i), read_mode, v[1:0]);
    end

    // R2 payload and single-cycle pulse
    prog_seq(21'h1F0F0F, 16'hBEEF, 1'b1);
    chk("R2 code", cmd_code, 1);
    chk("R2 addr", cmd_addr, 21'h1F0F0F);
    chk("R2 data", cmd_data, 16'hBEEF);
    @(negedge clk);
    chk("R2 one cycle", cmd_valid, 0);

    // R3 indices
    erase_seq(21'h0AB800, 8'h50, 1'b1);
    chk("R3 sector code", cmd_code, 2);
    chk("R3 sector index", cmd_index, 10'h157);
    erase_seq(21'h1F8000, 8'h30, 1'b1);
    chk("R3 block code", cmd_code, 3);
    chk("R3 block index", cmd_index, 10'h03F);

    // R10 protection by address
    prog_seq(21'h000100, 16'h1111, 1'b0);
    chk("R10 boot program dropped", cmd_valid, 0);
    prog_seq(21'h008000, 16'h2222, 1'b0);
    chk("R10 outside boot program", cmd_code, 1);
    erase_seq(21'h000800, 8'h50, 1'b0);
    chk("R10 boot sector dropped", cmd_valid, 0);
    erase_seq(21'h000800, 8'h50, 1'b1);
    chk("R10 boot sector unprotected", cmd_code, 2);

    // R11 suspend region
    erase_seq(21'h002800, 8'h50, 1'b1);
    chk("R11 erase issued", cmd_index, 10'd5);
    do_write(21'h000000, 16'h00B0, 1'b1, 1'b0, 1'b1);
    chk("R9 suspend code", cmd_code, 5);
    chk("R9 suspended set", erase_suspended, 1);
    prog_seq(21'h002801, 16'h3333, 1'b1);
    chk("R11 program in suspended sector", cmd_valid, 0);
    prog_seq(21'h003000, 16'h4444, 1'b1);
    chk("R11 program elsewhere", cmd_code, 1);
    erase_seq(21'h010000, 8'h50, 1'b1);
    chk("R11 erase while suspended", cmd_valid, 0);
    do_write(21'h0FFFFF, 16'h0030, 1'b1, 1'b0, 1'b0);
    chk("R9 resume code", cmd_code, 6);
    chk("R9 suspended cleared", erase_suspended, 0);

    // R12 reset mid-sequence
    do_write(21'h000555, 16'h00AA, 1'b1, 1'b0, 1'b0);
    do_write(21'h0002AA, 16'h0055, 1'b1, 1'b0, 1'b0);
    pulse_reset();
    do_write(21'h000555, 16'h00A0, 1'b1, 1'b0, 1'b0);
    chk("R12 third cycle", cmd_valid, 0);
    do_write(21'h012345, 16'h5634, 1'b1, 1'b0, 1'b0);
    chk("R12 data cycle", cmd_valid, 0);

    // R1 reset from query view
    do_write(21'h000055, 16'h0098, 1'b1, 1'b0, 1'b0);
    chk("R1 pre-reset mode", read_mode, 2);
    pulse_reset();
    chk("R1 mode after reset", read_mode, 0);
    chk("R1 valid after reset", cmd_valid, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule